// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

The walker turns a chain of in-memory descriptors into a stream of (address, length) fragments for a downstream data mover. A start pulse latches a base pointer. From there the block fetches each 8-byte descriptor as two 32-bit little-endian reads over a single-outstanding memory read port. The first word holds the byte count in bits [27:0] and an end-of-chain flag in bit 31. The second word holds the buffer address, of which only bits [30:0] are kept. Each decoded descriptor is presented once on a valid/ready fragment port. The walker holds it there until the consumer accepts it, and only then moves the pointer 8 bytes forward to fetch the next one.

The walk ends in one of three ways. A clean finish raises `done` after the flagged entry has been accepted. A read returning an error flag aborts the walk at once and pulses `err_mem`. A chain that runs to `MAX_ENTRIES` accepted fragments without a flag pulses `err_overrun`. Neither abort gives a completion. While a walk runs, `busy` is high and further start pulses are ignored.

Top module: `sgw_walker`

## Requirements
- R1: After reset `busy`, `frag_valid`, `mem_req`, `done`, `err_overrun` and `err_mem` are all low, and they stay low until a start pulse arrives.
- R2: For each descriptor the walker reads the length word at the descriptor pointer first, then the address word at pointer + 4, with at most one read outstanding (a `mem_req` is a single-cycle pulse, and the next one waits for `mem_rvalid`).
- R3: `frag_len` equals bits [27:0] of the length word; bits [30:28] have no effect on any output.
- R4: `frag_addr` equals bits [30:0] of the address word; bit 31 is discarded.
- R5: The first descriptor is read at `base_addr` as sampled with `start`, and the pointer advances by 8 bytes after each accepted non-final fragment.
- R6: A length word with bit 31 set yields a fragment with `frag_last` high. Once it is accepted, `done` pulses for one cycle in the next cycle, no further reads are issued, and `done` never coincides with an error pulse.
- R7: While `frag_valid` is high and `frag_ready` is low, the fragment stays valid and its address, length and last flag do not change. Every fragment is delivered exactly once, in list order.
- R8: If `MAX_ENTRIES` non-final fragments have been accepted, `err_overrun` pulses in the cycle after the last acceptance. No further read is issued and `done` does not pulse.
- R9: A response with `mem_rerr` high ends the walk: `err_mem` pulses in the next cycle, no fragment is built from that response, no further read is issued, and `done` does not pulse.
- R10: A start pulse while `busy` is high has no effect on the walk in progress: the base address it carries is never read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| base_addr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: final fragment accepted |
| err_overrun | output | 1 | One-cycle pulse: entry cap reached with no final flag |
| err_mem | output | 1 | One-cycle pulse: read returned an error |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error, qualified by `mem_rvalid` |
| frag_valid | output | 1 | Fragment offered |
| frag_ready | input | 1 | Consumer accepts the fragment |
| frag_addr | output | 31 | Fragment buffer address |
| frag_len | output | 28 | Fragment byte count |
| frag_last | output | 1 | Fragment ends the chain |

## Verification
Assertions check the cycle-level rules on every cycle:
- the fragment stays stable under backpressure;
- reads are single pulses;
- the block is quiet while idle;
- `done` only follows an accepted final fragment;
- `err_mem` only follows an errored response;
- the entry counter is never stepped past its cap.

The bench scenarios cover what needs an independent model of memory: the field masking, the exact order of read addresses, and the 8-byte stride. They also cover an overrun after the full default cap, an error on a mid-list address word, and a start pulse that must be ignored mid-walk.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int WORD_W     = 32;
    localparam int FRAG_AW    = 31;
    localparam int FRAG_LW    = 28;
    localparam int END_BIT    = 31;
    localparam int DESC_BYTES = 8;
    localparam int HI_OFFSET  = 4;

    typedef struct packed {
        logic [FRAG_AW-1:0] addr;
        logic [FRAG_LW-1:0] len;
        logic               last;
    } frag_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LEN,
        ST_WAIT_LEN,
        ST_REQ_ADR,
        ST_WAIT_ADR,
        ST_EMIT
    } walk_st_e;

    function automatic frag_t decode_desc(input logic [WORD_W-1:0] len_word,
                                          input logic [WORD_W-1:0] adr_word);
        frag_t f;
        f.addr = adr_word[FRAG_AW-1:0];
        f.len  = len_word[FRAG_LW-1:0];
        f.last = len_word[END_BIT];
        return f;
    endfunction

endpackage

// File: rtl/sgw_ptr_gen.sv
module sgw_ptr_gen #(
    parameter int AW     = 32,
    parameter int STEP   = 8,
    parameter int HI_OFS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          sel_hi,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);
    localparam logic [AW-1:0] HI_V   = AW'(HI_OFS);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= base;
        end else if (adv) begin
            ptr_q <= ptr_q + STEP_V;
        end
    end

    assign addr = sel_hi ? (ptr_q + HI_V) : ptr_q;

    AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && adv)); // R5

endmodule

// File: rtl/sgw_desc_latch.sv
module sgw_desc_latch
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_len,
    input  logic              cap_adr,
    input  logic [WORD_W-1:0] rdata,
    output frag_t             frag
);
    logic [WORD_W-1:0] len_word_q;
    frag_t             frag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_word_q <= '0;
            frag_q     <= '0;
        end else begin
            if (cap_len) len_word_q <= rdata;
            if (cap_adr) frag_q     <= decode_desc(len_word_q, rdata);
        end
    end

    assign frag = frag_q;

    AST_CAP_ORDER: assert property (@(posedge clk) disable iff (rst)
        cap_len |=> !cap_adr); // R2

endmodule

// File: rtl/sgw_entry_ctr.sv
module sgw_entry_ctr #(
    parameter int MAX_ENTRIES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_cap
);
    localparam int CNT_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(MAX_ENTRIES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_cap = (cnt_q == CAP_V);

    AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        inc |-> !at_cap); // R8

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int MAX_ENTRIES = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WORD_W-1:0]  base_addr,
    output logic               busy,
    output logic               done,
    output logic               err_overrun,
    output logic               err_mem,
    output logic               mem_req,
    output logic [WORD_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_rerr,
    output logic               frag_valid,
    input  logic               frag_ready,
    output logic [FRAG_AW-1:0] frag_addr,
    output logic [FRAG_LW-1:0] frag_len,
    output logic               frag_last
);
    walk_st_e st_q, st_d;
    logic     done_q, ovr_q, merr_q;
    logic     launch, emit_hs, step, cap_len, cap_adr, at_cap, rd_ok, rd_bad;
    frag_t    frag;

    assign launch  = (st_q == ST_IDLE) && start;
    assign emit_hs = (st_q == ST_EMIT) && frag_ready;
    assign step    = emit_hs && !frag.last && !at_cap;
    assign rd_ok   = mem_rvalid && !mem_rerr;
    assign rd_bad  = mem_rvalid && mem_rerr;
    assign cap_len = (st_q == ST_WAIT_LEN) && rd_ok;
    assign cap_adr = (st_q == ST_WAIT_ADR) && rd_ok;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start) st_d = ST_REQ_LEN;
            ST_REQ_LEN:  st_d = ST_WAIT_LEN;
            ST_WAIT_LEN: if (rd_bad) st_d = ST_IDLE;
                         else if (rd_ok) st_d = ST_REQ_ADR;
            ST_REQ_ADR:  st_d = ST_WAIT_ADR;
            ST_WAIT_ADR: if (rd_bad) st_d = ST_IDLE;
                         else if (rd_ok) st_d = ST_EMIT;
            ST_EMIT:     if (frag_ready) st_d = step ? ST_REQ_LEN : ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            merr_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= emit_hs && frag.last;
            ovr_q  <= emit_hs && !frag.last && at_cap;
            merr_q <= ((st_q == ST_WAIT_LEN) || (st_q == ST_WAIT_ADR)) && rd_bad;
        end
    end

    sgw_ptr_gen #(
        .AW     (WORD_W),
        .STEP   (DESC_BYTES),
        .HI_OFS (HI_OFFSET)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .load   (launch),
        .base   (base_addr),
        .adv    (step),
        .sel_hi (st_q == ST_REQ_ADR),
        .addr   (mem_addr)
    );

    sgw_desc_latch u_desc (
        .clk     (clk),
        .rst     (rst),
        .cap_len (cap_len),
        .cap_adr (cap_adr),
        .rdata   (mem_rdata),
        .frag    (frag)
    );

    sgw_entry_ctr #(
        .MAX_ENTRIES (MAX_ENTRIES)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (launch),
        .inc    (step),
        .at_cap (at_cap)
    );

    assign busy        = (st_q != ST_IDLE);
    assign mem_req     = (st_q == ST_REQ_LEN) || (st_q == ST_REQ_ADR);
    assign frag_valid  = (st_q == ST_EMIT);
    assign frag_addr   = frag.addr;
    assign frag_len    = frag.len;
    assign frag_last   = frag.last;
    assign done        = done_q;
    assign err_overrun = ovr_q;
    assign err_mem     = merr_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!frag_valid && !mem_req)); // R1
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R2
    AST_FRAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_addr)
                                         && $stable(frag_len) && $stable(frag_last))); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(frag_valid && frag_ready && frag_last)); // R6
    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({done, err_overrun, err_mem}) <= 1); // R6
    AST_MERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_mem |-> $past(mem_rvalid && mem_rerr)); // R9

endmodule

// File: tb/sgw_walker_tb.sv
module sgw_walker_tb;
    import sgw_pkg::*;

    localparam int MAXE = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [31:0] base_addr = '0;
    logic busy, done, err_overrun, err_mem;
    logic mem_req;
    logic [31:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic mem_rerr = 1'b0;
    logic frag_valid;
    logic frag_ready = 1'b0;
    logic [FRAG_AW-1:0] frag_addr;
    logic [FRAG_LW-1:0] frag_len;
    logic frag_last;

    always #2 clk = ~clk;

    sgw_walker #(.MAX_ENTRIES(MAXE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .busy(busy), .done(done), .err_overrun(err_overrun), .err_mem(err_mem),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_addr(frag_addr), .frag_len(frag_len), .frag_last(frag_last)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int done_cnt = 0, ovr_cnt = 0, merr_cnt = 0;
    int lat = 1;
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic err_en = 1'b0;
    logic [31:0] err_addr = '0;

    logic [31:0] mem [int unsigned];
    frag_t exp_frag_q[$];
    logic [31:0] exp_addr_q[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: single-outstanding, fixed latency, sampled on negedge
    initial begin
        int pend = 0;
        logic pending = 1'b0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
            if (pending) begin
                pend--;
                if (pend <= 0) begin
                    pending    = 1'b0;
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem.exists(paddr) ? mem[paddr] : 32'h0;
                    mem_rerr   = err_en && (paddr == err_addr);
                end
            end
            if (mem_req) begin
                if (exp_addr_q.size() == 0) begin
                    check(1'b0, "R2 unexpected read", {32'h0, mem_addr}, 64'h0);
                end else begin
                    logic [31:0] ea;
                    ea = exp_addr_q.pop_front();
                    check(mem_addr == ea, "R2/R5 read address", {32'h0, mem_addr}, {32'h0, ea});
                end
                pending = 1'b1;
                pend    = lat;
                paddr   = mem_addr;
            end
        end
    end

    // consumer + scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0: frag_ready = 1'b1;
                1: frag_ready = ~frag_ready;
                default: frag_ready = lfsr[0] | lfsr[3];
            endcase
            if (done) done_cnt++;
            if (err_overrun) ovr_cnt++;
            if (err_mem) merr_cnt++;
            if (frag_valid && frag_ready) begin
                if (exp_frag_q.size() == 0) begin
                    check(1'b0, "R7 unexpected fragment", {4'h0, frag_addr, frag_len, frag_last}, 64'h0);
                end else begin
                    frag_t ef;
                    frag_t af;
                    ef = exp_frag_q.pop_front();
                    af.addr = frag_addr;
                    af.len  = frag_len;
                    af.last = frag_last;
                    check(af == ef, "R3/R4/R6/R7 fragment", {4'h0, af}, {4'h0, ef});
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // driver: writes a list and pushes expectations
    task automatic build_list(input logic [31:0] base, input int n, input bit has_last,
                              input int exp_frags, input int exp_reqs);
        for (int i = 0; i < n; i++) begin
            logic [31:0] lw, aw;
            frag_t f;
            lw = {1'b0, 3'(i % 8), 28'((base * 3 + i * 32'h1357) & 32'h0FFF_FFFF)};
            if (has_last && i == n - 1) lw[31] = 1'b1;
            aw = {1'(i % 2), 31'(32'h0040_0000 + base + i * 32'h100)};
            mem[base + 32'(i * 8)]     = lw;
            mem[base + 32'(i * 8) + 4] = aw;
            f.addr = aw[30:0];
            f.len  = lw[27:0];
            f.last = lw[31];
            if (i < exp_frags) exp_frag_q.push_back(f);
            if (2 * i < exp_reqs) exp_addr_q.push_back(base + 32'(i * 8));
            if (2 * i + 1 < exp_reqs) exp_addr_q.push_back(base + 32'(i * 8) + 4);
        end
    endtask

    task automatic pulse_start(input logic [31:0] b);
        @(negedge clk);
        start = 1'b1;
        base_addr = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_walk(input logic [31:0] b, input int extra_at, input logic [31:0] b2,
                            input int exp_done, input int exp_ovr, input int exp_merr, input string tag);
        int d0, o0, m0, k;
        d0 = done_cnt; o0 = ovr_cnt; m0 = merr_cnt;
        pulse_start(b);
        k = 0;
        while ((done_cnt + ovr_cnt + merr_cnt) == (d0 + o0 + m0) && k < 20000) begin
            @(negedge clk);
            k++;
            if (k == extra_at) begin
                check(busy == 1'b1, "R10 busy at extra start", {63'h0, busy}, 64'h1);
                start = 1'b1; base_addr = b2;
                @(negedge clk);
                start = 1'b0;
            end
        end
        repeat (8) @(negedge clk);
        check(exp_frag_q.size() == 0, {tag, " fragments all delivered"}, exp_frag_q.size(), 0);
        check(exp_addr_q.size() == 0, {tag, " reads all issued"}, exp_addr_q.size(), 0);
        check(done_cnt - d0 == exp_done, {tag, " done pulses"}, done_cnt - d0, exp_done);
        check(ovr_cnt - o0 == exp_ovr, {tag, " overrun pulses"}, ovr_cnt - o0, exp_ovr);
        check(merr_cnt - m0 == exp_merr, {tag, " mem error pulses"}, merr_cnt - m0, exp_merr);
        check(busy == 1'b0, {tag, " idle at end"}, {63'h0, busy}, 64'h0);
        exp_frag_q.delete();
        exp_addr_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy after reset", {63'h0, busy}, 0);
        check(frag_valid == 0, "R1 frag_valid after reset", {63'h0, frag_valid}, 0);
        check(mem_req == 0, "R1 mem_req after reset", {63'h0, mem_req}, 0);
        check({done, err_overrun, err_mem} == 0, "R1 status after reset",
              {61'h0, done, err_overrun, err_mem}, 0);

        // R3 R4 R5 R6: three entries, ready always, latency 1
        lat = 1; ready_mode = 0;
        build_list(32'h0000_1000, 3, 1'b1, 3, 6);
        run_walk(32'h0000_1000, -1, 0, 1, 0, 0, "R6 basic");

        // R7 R10: five entries, random backpressure, latency 3, stray start mid-walk
        lat = 3; ready_mode = 2;
        build_list(32'h0000_3000, 5, 1'b1, 5, 10);
        run_walk(32'h0000_3000, 12, 32'h0000_9000, 1, 0, 0, "R7 R10 backpressure");

        // R7: alternating ready, latency 2
        lat = 2; ready_mode = 1;
        build_list(32'h0000_5008, 4, 1'b1, 4, 8);
        run_walk(32'h0000_5008, -1, 0, 1, 0, 0, "R7 alternating");

        // R9: error on address word of second entry
        lat = 1; ready_mode = 0;
        err_en = 1'b1; err_addr = 32'h0000_200C;
        build_list(32'h0000_2000, 3, 1'b1, 1, 4);
        run_walk(32'h0000_2000, -1, 0, 0, 0, 1, "R9 mem error");
        err_en = 1'b0;

        // R8: full cap without final flag
        lat = 1; ready_mode = 0;
        build_list(32'h0001_0000, MAXE, 1'b0, MAXE, 2 * MAXE);
        run_walk(32'h0001_0000, -1, 0, 0, 1, 0, "R8 overrun");

        // R6: single final entry, boundary
        build_list(32'h0000_7000, 1, 1'b1, 1, 2);
        run_walk(32'h0000_7000, -1, 0, 1, 0, 0, "R6 single");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule